// File: doc/BRIEF.md
# Accumulator Word Machine Core

This block is a small multicycle processor for a machine with a 24-bit word. It has one accumulator (A), an index register (X), a link register (L), a 15-bit program counter and a two-bit condition code. The core moves one byte per cycle to and from a synchronous byte-wide memory. Read data appears one cycle after the address is presented. Writes take effect at the clock edge while the write strobe is high.

Each instruction takes three bytes. The core fetches it, forms a direct or indexed target address, and then does one of the following: loads or stores a full word, does accumulator arithmetic, compares, steps the index register, moves a single byte, branches, or calls and returns through the link register. An opcode outside the supported set stops the core, and the halt output then stays high until reset.

Top module: `acc24_core`

## Requirements
- R1: While reset is low and at the first cycle after it, `halt` is 0, `mem_we` is 0 and `mem_addr` is 0. Reset clears A, X, L, the program counter and the condition code (a stored register reads back as 000000).
- R2: The core fetches an instruction as three reads at consecutive addresses starting at the program counter, most significant byte first. Bits 23:16 are the opcode, bit 15 is the index flag and bits 14:0 are the address field.
- R3: With the index flag at 0, the target address is the address field. With the flag at 1, it is the address field plus X[14:0], taken modulo 2^15.
- R4: Opcodes 00, 04 and 08 load a word into A, X and L. Opcodes 0C, 10 and 14 store A, X and L as three writes at ascending addresses from the target, most significant byte first.
- R5: ADD (18) and SUB (1C) combine A with the word at the target, modulo 2^24, and place the result in A.
- R6: COMP (28) compares A with the word at the target as signed values. It sets the condition code to 00 for less, 01 for equal and 10 for greater.
- R7: JLT (38), JEQ (30) and JGT (34) go to the target only when the condition code matches, and otherwise continue with the next instruction. J (3C) always goes to the target.
- R8: JSUB (48) writes the address of the following instruction into L and goes to the target. RSUB (4C) continues at L[14:0].
- R9: TIX (2C) adds one to X and compares the new X with the word at the target, setting the condition code as R6 does. An indexed target uses X as it was before the increment.
- R10: LDCH (50) replaces A[7:0] with the byte at the target and keeps A[23:8]. STCH (54) performs exactly one write of A[7:0] to the target.
- R11: Any other opcode raises `halt`. `halt` then stays high and no further writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 15 | Byte address for the current memory cycle |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | 8 | Byte read from the address of the previous cycle |
| halt | output | 1 | High once an undefined opcode has been decoded |

## Verification
Arithmetic is tried with a sum that goes negative and with a sum that wraps to zero, which separates modulo-2^24 behaviour from saturation. Comparisons are run against a larger value, an equal value and an all-ones word. The all-ones case is the one that tells signed from unsigned comparison. Indexing is tried with a plain offset, with an offset that wraps past the top of the address space, and with a stepped index. The stepped case shows whether the target was formed from X before or after its increment. Every branch is paired with a trap path, so a wrong decision shows up as a stray memory write.

// File: rtl/acc24_pkg.sv
package acc24_pkg;

   localparam int OPC_W = 8;

   localparam logic [OPC_W-1:0] OP_LDA  = 8'h00;
   localparam logic [OPC_W-1:0] OP_LDX  = 8'h04;
   localparam logic [OPC_W-1:0] OP_LDL  = 8'h08;
   localparam logic [OPC_W-1:0] OP_STA  = 8'h0C;
   localparam logic [OPC_W-1:0] OP_STX  = 8'h10;
   localparam logic [OPC_W-1:0] OP_STL  = 8'h14;
   localparam logic [OPC_W-1:0] OP_ADD  = 8'h18;
   localparam logic [OPC_W-1:0] OP_SUB  = 8'h1C;
   localparam logic [OPC_W-1:0] OP_COMP = 8'h28;
   localparam logic [OPC_W-1:0] OP_TIX  = 8'h2C;
   localparam logic [OPC_W-1:0] OP_JEQ  = 8'h30;
   localparam logic [OPC_W-1:0] OP_JGT  = 8'h34;
   localparam logic [OPC_W-1:0] OP_JLT  = 8'h38;
   localparam logic [OPC_W-1:0] OP_J    = 8'h3C;
   localparam logic [OPC_W-1:0] OP_JSUB = 8'h48;
   localparam logic [OPC_W-1:0] OP_RSUB = 8'h4C;
   localparam logic [OPC_W-1:0] OP_LDCH = 8'h50;
   localparam logic [OPC_W-1:0] OP_STCH = 8'h54;

   typedef enum logic [1:0] {
      CC_LT = 2'b00,
      CC_EQ = 2'b01,
      CC_GT = 2'b10
   } cc_t;

   typedef enum logic [3:0] {
      K_LOAD, K_STORE, K_ADD, K_SUB, K_COMP, K_TIX,
      K_JMP, K_JSUB, K_RSUB, K_LDCH, K_STCH, K_BAD
   } kind_t;

   typedef enum logic [1:0] {
      RS_A, RS_X, RS_L
   } rsel_t;

   typedef enum logic [1:0] {
      BC_ALW, BC_LT, BC_EQ, BC_GT
   } bcond_t;

   typedef struct packed {
      kind_t  kind;
      rsel_t  rsel;
      bcond_t bcond;
   } dec_t;

   typedef enum logic [2:0] {
      ST_FETCH, ST_DECODE, ST_READ, ST_EXEC, ST_WRITE, ST_HALT
   } state_t;

endpackage

// File: rtl/acc24_decode.sv
module acc24_decode
   import acc24_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output dec_t             dec
);

   always_comb begin
      dec = '{kind: K_BAD, rsel: RS_A, bcond: BC_ALW};
      case (opcode)
         OP_LDA:  dec.kind = K_LOAD;
         OP_LDX:  begin dec.kind = K_LOAD;  dec.rsel = RS_X; end
         OP_LDL:  begin dec.kind = K_LOAD;  dec.rsel = RS_L; end
         OP_STA:  dec.kind = K_STORE;
         OP_STX:  begin dec.kind = K_STORE; dec.rsel = RS_X; end
         OP_STL:  begin dec.kind = K_STORE; dec.rsel = RS_L; end
         OP_ADD:  dec.kind = K_ADD;
         OP_SUB:  dec.kind = K_SUB;
         OP_COMP: dec.kind = K_COMP;
         OP_TIX:  dec.kind = K_TIX;
         OP_J:    dec.kind = K_JMP;
         OP_JLT:  begin dec.kind = K_JMP; dec.bcond = BC_LT; end
         OP_JEQ:  begin dec.kind = K_JMP; dec.bcond = BC_EQ; end
         OP_JGT:  begin dec.kind = K_JMP; dec.bcond = BC_GT; end
         OP_JSUB: dec.kind = K_JSUB;
         OP_RSUB: dec.kind = K_RSUB;
         OP_LDCH: dec.kind = K_LDCH;
         OP_STCH: dec.kind = K_STCH;
         default: ;
      endcase
   end

endmodule

// File: rtl/acc24_agu.sv
module acc24_agu #(
   parameter int ADDR_W = 15
) (
   input  logic [ADDR_W-1:0] field,
   input  logic              idx_en,
   input  logic [ADDR_W-1:0] xlow,
   output logic [ADDR_W-1:0] ta
);

   always_comb begin
      ta = field + (idx_en ? xlow : '0);
   end

endmodule

// File: rtl/acc24_alu.sv
module acc24_alu #(
   parameter int WORD_W     = 24,
   parameter int SIGNED_CMP = 1
) (
   input  logic [WORD_W-1:0] lhs,
   input  logic [WORD_W-1:0] rhs,
   input  logic              do_sub,
   output logic [WORD_W-1:0] res,
   output logic              lt,
   output logic              eq
);

   assign res = do_sub ? (lhs - rhs) : (lhs + rhs);
   assign eq  = (lhs == rhs);

   generate
      if (SIGNED_CMP != 0) begin : g_signed
         assign lt = ($signed(lhs) < $signed(rhs));
      end else begin : g_unsigned
         assign lt = (lhs < rhs);
      end
   endgenerate

endmodule

// File: rtl/acc24_core.sv
module acc24_core
   import acc24_pkg::*;
#(
   parameter int WORD_W     = 24,
   parameter int BYTE_W     = 8,
   parameter int ADDR_W     = 15,
   parameter int SIGNED_CMP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              halt
);

   localparam int NBYTES = WORD_W / BYTE_W;
   localparam int CNT_W  = $clog2(NBYTES + 1);
   localparam int FLD_W  = WORD_W - 1 - ADDR_W;

   generate
      if (WORD_W % BYTE_W != 0) begin : g_bad_word
         $error("word width must be a whole number of bytes");
      end
      if (FLD_W != OPC_W) begin : g_bad_fmt
         $error("opcode field must be exactly OPC_W bits");
      end
      if (ADDR_W <= CNT_W) begin : g_bad_addr
         $error("address width too small");
      end
   endgenerate

   state_t            state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] pc_q, ta_q;
   logic [WORD_W-1:0] a_q, x_q, l_q, ir_q, mdr_q;
   cc_t               cc_q;

   dec_t              dec;
   logic [ADDR_W-1:0] ta_c;
   logic [ADDR_W-1:0] pc_inc;
   logic [ADDR_W-1:0] cnt_ext;
   logic [WORD_W-1:0] alu_lhs, alu_res;
   logic              alu_lt, alu_eq;
   logic              single;
   logic [CNT_W-1:0]  xfer_n;
   logic              take;
   logic [WORD_W-1:0] src_w;
   logic [BYTE_W-1:0] wbyte;

   acc24_decode u_dec (
      .opcode (ir_q[WORD_W-1 -: OPC_W]),
      .dec    (dec)
   );

   acc24_agu #(.ADDR_W(ADDR_W)) u_agu (
      .field  (ir_q[ADDR_W-1:0]),
      .idx_en (ir_q[ADDR_W]),
      .xlow   (x_q[ADDR_W-1:0]),
      .ta     (ta_c)
   );

   assign alu_lhs = (dec.kind == K_TIX) ? x_q : a_q;

   acc24_alu #(.WORD_W(WORD_W), .SIGNED_CMP(SIGNED_CMP)) u_alu (
      .lhs    (alu_lhs),
      .rhs    (mdr_q),
      .do_sub (dec.kind != K_ADD),
      .res    (alu_res),
      .lt     (alu_lt),
      .eq     (alu_eq)
   );

   assign pc_inc  = pc_q + ADDR_W'(NBYTES);
   assign cnt_ext = {{(ADDR_W-CNT_W){1'b0}}, cnt_q};
   assign single  = (dec.kind == K_LDCH) || (dec.kind == K_STCH);
   assign xfer_n  = single ? CNT_W'(1) : CNT_W'(NBYTES);

   always_comb begin
      case (dec.bcond)
         BC_LT:   take = (cc_q == CC_LT);
         BC_EQ:   take = (cc_q == CC_EQ);
         BC_GT:   take = (cc_q == CC_GT);
         default: take = 1'b1;
      endcase
   end

   always_comb begin
      case (dec.rsel)
         RS_X:    src_w = x_q;
         RS_L:    src_w = l_q;
         default: src_w = a_q;
      endcase
   end

   always_comb begin
      wbyte = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (cnt_q == CNT_W'(i)) begin
            wbyte = src_w[BYTE_W*(NBYTES-1-i) +: BYTE_W];
         end
      end
   end

   always_comb begin
      case (state_q)
         ST_FETCH:          mem_addr = pc_q + cnt_ext;
         ST_READ, ST_WRITE: mem_addr = ta_q + cnt_ext;
         default:           mem_addr = pc_q;
      endcase
   end

   assign mem_we    = (state_q == ST_WRITE);
   assign mem_wdata = single ? a_q[BYTE_W-1:0] : wbyte;
   assign halt      = (state_q == ST_HALT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FETCH;
         cnt_q   <= '0;
         pc_q    <= '0;
         ta_q    <= '0;
         a_q     <= '0;
         x_q     <= '0;
         l_q     <= '0;
         ir_q    <= '0;
         mdr_q   <= '0;
         cc_q    <= CC_LT;
      end else begin
         case (state_q)
            ST_FETCH: begin
               if (cnt_q != '0) begin
                  ir_q <= {ir_q[WORD_W-BYTE_W-1:0], mem_rdata};
               end
               if (cnt_q == CNT_W'(NBYTES)) begin
                  cnt_q   <= '0;
                  state_q <= ST_DECODE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end

            ST_DECODE: begin
               ta_q    <= ta_c;
               pc_q    <= pc_inc;
               state_q <= ST_FETCH;
               case (dec.kind)
                  K_BAD: begin
                     pc_q    <= pc_q;
                     state_q <= ST_HALT;
                  end
                  K_LOAD, K_ADD, K_SUB, K_COMP, K_LDCH: state_q <= ST_READ;
                  K_TIX: begin
                     x_q     <= x_q + 1'b1;
                     state_q <= ST_READ;
                  end
                  K_STORE, K_STCH: state_q <= ST_WRITE;
                  K_JMP: begin
                     if (take) pc_q <= ta_c;
                  end
                  K_JSUB: begin
                     l_q  <= {{(WORD_W-ADDR_W){1'b0}}, pc_inc};
                     pc_q <= ta_c;
                  end
                  K_RSUB: pc_q <= l_q[ADDR_W-1:0];
                  default: ;
               endcase
            end

            ST_READ: begin
               if (cnt_q != '0) begin
                  mdr_q <= {mdr_q[WORD_W-BYTE_W-1:0], mem_rdata};
               end
               if (cnt_q == xfer_n) begin
                  cnt_q   <= '0;
                  state_q <= ST_EXEC;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end

            ST_EXEC: begin
               state_q <= ST_FETCH;
               case (dec.kind)
                  K_LOAD: begin
                     case (dec.rsel)
                        RS_X:    x_q <= mdr_q;
                        RS_L:    l_q <= mdr_q;
                        default: a_q <= mdr_q;
                     endcase
                  end
                  K_ADD, K_SUB:  a_q <= alu_res;
                  K_COMP, K_TIX: cc_q <= alu_lt ? CC_LT : (alu_eq ? CC_EQ : CC_GT);
                  K_LDCH:        a_q[BYTE_W-1:0] <= mdr_q[BYTE_W-1:0];
                  default: ;
               endcase
            end

            ST_WRITE: begin
               if (cnt_q == xfer_n - 1'b1) begin
                  cnt_q   <= '0;
                  state_q <= ST_FETCH;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end

            ST_HALT: state_q <= ST_HALT;

            default: state_q <= ST_HALT;
         endcase
      end
   end

endmodule

// File: rtl/acc24_core_chk.sv
module acc24_core_chk
   import acc24_pkg::*;
#(
   parameter int WORD_W = 24,
   parameter int ADDR_W = 15,
   parameter int CNT_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              halt,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input state_t            st,
   input logic [CNT_W-1:0]  cnt,
   input kind_t             kind,
   input logic [ADDR_W-1:0] ta_c,
   input logic [WORD_W-1:0] xreg,
   input cc_t               cc
);

   logic [ADDR_W-1:0] addr_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_prev <= '0;
      else        addr_prev <= mem_addr;
   end

   // R11: once stopped, the core stays stopped
   a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> halt);

   // R11: a stopped core does not write
   a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> !mem_we);

   // R2: instruction bytes come from consecutive addresses
   a_r2_fetch_seq: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FETCH && cnt != '0) |-> (mem_addr == addr_prev + 1'b1));

   // R8: a call continues fetching at its target
   a_r8_call_target: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DECODE && kind == K_JSUB) |=> (mem_addr == $past(ta_c)));

   // R9: the index step adds exactly one
   a_r9_tix_step: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DECODE && kind == K_TIX) |=> (xreg == $past(xreg) + 1'b1));

   // R6: the condition code never takes the unused encoding
   a_r6_cc_legal: assert property (@(posedge clk) disable iff (!rst_n)
      cc != 2'b11);

endmodule

bind acc24_core acc24_core_chk #(
   .WORD_W (WORD_W),
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .halt     (halt),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .st       (state_q),
   .cnt      (cnt_q),
   .kind     (dec.kind),
   .ta_c     (ta_c),
   .xreg     (x_q),
   .cc       (cc_q)
);

// File: tb/acc24_core_tb.sv
`timescale 1ns/1ps
module acc24_core_tb;

   localparam logic [7:0] LDA = 8'h00, LDX = 8'h04, LDL = 8'h08, STA = 8'h0C,
                          STX = 8'h10, STL = 8'h14, ADD = 8'h18, SUB = 8'h1C,
                          COMP = 8'h28, TIX = 8'h2C, JEQ = 8'h30, JGT = 8'h34,
                          JLT = 8'h38, JMP = 8'h3C, JSUB = 8'h48, RSUB = 8'h4C,
                          LDCH = 8'h50, STCH = 8'h54, BADOP = 8'hFF;
   localparam int TRAP = 'h200;
   localparam int SUBR = 'h280;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_we;
   logic [7:0]  mem_rdata = 8'h00;
   logic        halt;

   logic [7:0]  mem [0:4095];

   int          n_chk = 0;
   int          n_fail = 0;
   int          pcw;
   int          q_a[$];
   logic [7:0]  q_d[$];
   string       q_t[$];
   int          ea;
   logic [7:0]  ed;
   string       et;
   logic [7:0]  lbyte;
   int          ret;

   always #2 clk = ~clk;

   acc24_core u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata),
      .halt      (halt)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[11:0]];
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic put_byte(input int ad, input logic [7:0] b);
      mem[ad[11:0]] = b;
   endtask

   task automatic put_word(input int ad, input logic [23:0] w);
      put_byte(ad, w[23:16]);
      put_byte(ad + 1, w[15:8]);
      put_byte(ad + 2, w[7:0]);
   endtask

   task automatic emit(input logic [7:0] op, input logic xb, input int ad);
      put_word(pcw, {op, xb, ad[14:0]});
      pcw += 3;
   endtask

   task automatic exp_byte(input int ad, input logic [7:0] b, input string tag);
      q_a.push_back(ad);
      q_d.push_back(b);
      q_t.push_back(tag);
   endtask

   task automatic exp_word(input int ad, input logic [23:0] w, input string tag);
      exp_byte(ad, w[23:16], tag);
      exp_byte(ad + 1, w[15:8], tag);
      exp_byte(ad + 2, w[7:0], tag);
   endtask

   // scoreboard monitor: every write must match the next expected item
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         if (q_a.size() == 0) begin
            chk(1'b0, "R11", "unexpected write", {17'b0, mem_addr}, 32'hFFFF);
         end else begin
            ea = q_a.pop_front();
            ed = q_d.pop_front();
            et = q_t.pop_front();
            chk(mem_addr == ea[14:0], et, "write address", {17'b0, mem_addr}, ea);
            chk(mem_wdata == ed, et, "write data", {24'b0, mem_wdata}, {24'b0, ed});
         end
      end
   end

   task automatic build_program();
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      // data area
      put_word('h300, 24'h000005);
      put_word('h303, 24'h000007);
      put_word('h306, 24'h000014);
      put_word('h309, 24'hFFFFFF);
      put_word('h30C, 24'h000001);
      put_word('h30F, 24'h000002);
      put_word('h316, 24'h123456);
      put_word('h319, 24'h00ABCD);
      put_word('h31C, 24'h200000);
      put_word('h322, 24'h000003);
      put_word('h326, 24'h000005);
      // trap: any arrival here makes a stray write, then stops
      pcw = TRAP;
      emit(STCH, 1'b0, 'h4FF);
      emit(BADOP, 1'b0, 0);
      // subroutine
      pcw = SUBR;
      emit(STL, 1'b0, 'h41C);
      emit(RSUB, 1'b0, 0);
      // main program
      pcw = 0;
      emit(STA, 1'b0, 'h3F0); exp_word('h3F0, 24'h0, "R1");
      lbyte = mem[1];
      put_word('h31F, {16'h1234, lbyte});
      emit(STX, 1'b0, 'h3F3); exp_word('h3F3, 24'h0, "R1");
      emit(STL, 1'b0, 'h3F6); exp_word('h3F6, 24'h0, "R1");
      emit(LDA, 1'b0, 'h300);
      emit(ADD, 1'b0, 'h303);
      emit(SUB, 1'b0, 'h306);
      emit(STA, 1'b0, 'h400); exp_word('h400, 24'hFFFFF8, "R5");
      emit(LDA, 1'b0, 'h309);
      emit(ADD, 1'b0, 'h30C);
      emit(STA, 1'b0, 'h403); exp_word('h403, 24'h000000, "R5");
      emit(LDX, 1'b0, 'h30F);
      emit(LDA, 1'b1, 'h314);
      emit(STA, 1'b0, 'h406); exp_word('h406, 24'h123456, "R3");
      emit(LDCH, 1'b1, 'h7FFF);
      emit(STA, 1'b0, 'h409); exp_word('h409, {16'h1234, lbyte}, "R10");
      emit(STCH, 1'b0, 'h40C); exp_byte('h40C, lbyte, "R10");
      emit(STX, 1'b0, 'h40D); exp_word('h40D, 24'h000002, "R4");
      emit(LDL, 1'b0, 'h319);
      emit(STL, 1'b0, 'h410); exp_word('h410, 24'h00ABCD, "R4");
      // less than
      emit(COMP, 1'b0, 'h31C);
      emit(JEQ, 1'b0, TRAP);
      emit(JGT, 1'b0, TRAP);
      emit(JLT, 1'b0, pcw + 6);
      emit(JMP, 1'b0, TRAP);
      emit(STCH, 1'b0, 'h413); exp_byte('h413, lbyte, "R7");
      // greater than, signed against all ones
      emit(COMP, 1'b0, 'h309);
      emit(JLT, 1'b0, TRAP);
      emit(JEQ, 1'b0, TRAP);
      emit(JGT, 1'b0, pcw + 6);
      emit(JMP, 1'b0, TRAP);
      emit(STCH, 1'b0, 'h414); exp_byte('h414, lbyte, "R6");
      // equal
      emit(COMP, 1'b0, 'h31F);
      emit(JLT, 1'b0, TRAP);
      emit(JGT, 1'b0, TRAP);
      emit(JEQ, 1'b0, pcw + 6);
      emit(JMP, 1'b0, TRAP);
      emit(STCH, 1'b0, 'h415); exp_byte('h415, lbyte, "R6");
      // index step
      emit(TIX, 1'b0, 'h322);
      emit(JEQ, 1'b0, pcw + 6);
      emit(JMP, 1'b0, TRAP);
      emit(STX, 1'b0, 'h416); exp_word('h416, 24'h000003, "R9");
      emit(TIX, 1'b0, 'h322);
      emit(JGT, 1'b0, pcw + 6);
      emit(JMP, 1'b0, TRAP);
      emit(TIX, 1'b1, 'h322);
      emit(JEQ, 1'b0, pcw + 6);
      emit(JMP, 1'b0, TRAP);
      emit(STX, 1'b0, 'h419); exp_word('h419, 24'h000005, "R9");
      // call and return
      emit(JSUB, 1'b0, SUBR);
      ret = pcw;
      exp_word('h41C, ret[23:0], "R8");
      emit(STCH, 1'b0, 'h41F); exp_byte('h41F, lbyte, "R8");
      // unconditional jump over a trap, then stop
      emit(JMP, 1'b0, pcw + 6);
      emit(JMP, 1'b0, TRAP);
      emit(BADOP, 1'b0, 0);
   endtask

   initial begin
      int cyc;
      build_program();
      repeat (3) @(negedge clk);
      chk(halt == 1'b0, "R1", "halt in reset", {31'b0, halt}, 0);
      chk(mem_we == 1'b0, "R1", "write strobe in reset", {31'b0, mem_we}, 0);
      chk(mem_addr == 15'h0, "R1", "address in reset", {17'b0, mem_addr}, 0);
      rst_n = 1'b1;
      chk(mem_addr == 15'h0, "R2", "fetch byte 0", {17'b0, mem_addr}, 0);
      @(negedge clk);
      chk(mem_addr == 15'h1, "R2", "fetch byte 1", {17'b0, mem_addr}, 1);
      @(negedge clk);
      chk(mem_addr == 15'h2, "R2", "fetch byte 2", {17'b0, mem_addr}, 2);
      cyc = 0;
      while (!halt && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      chk(halt == 1'b1, "R11", "watchdog, halt not reached", {31'b0, halt}, 1);
      repeat (20) @(negedge clk);
      chk(halt == 1'b1, "R11", "halt held", {31'b0, halt}, 1);
      chk(q_a.size() == 0, "R4", "writes still expected", q_a.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule